// File: doc/BRIEF.md
# Radix-4 Signed-Digit Carry-Free Adder/Subtractor

This block adds or subtracts two signed binary operands by first rewriting each one as a vector of radix-4 signed digits. Each digit lies in -3..+3 and is held as a 3-bit two's complement code. Every digit position then works out its result in two fixed steps, and no step waits on a neighbour further away than the next lower position. As a result, the depth of the adder core stays the same whatever the operand width.

A control input picks addition or subtraction. For subtraction, every digit of the second operand is negated before the first step, so no borrow ever travels along the vector. The block returns two results:
- the signed-digit result, one digit wider than the operands;
- the same result folded back to a plain two's complement value, so that a binary datapath can consume it.

Both outputs are registered. They reflect the inputs present at the previous rising clock edge.

Top module: `qsd_addsub`

## Requirements
- R1: Every output digit is a 3-bit two's complement code in -3..+3. The code 3'b100 never appears. Digit k occupies bits [3k+2:3k] of `res_dig_o`.
- R2: An operand of 2·NDIG bits is split into NDIG digits. Digit k (k < NDIG-1) is the unsigned bit pair [2k+1:2k], valued 0..3. The top digit is the top bit pair read as a signed value, valued -2..+1.
- R3: At each position, the raw sum of the two digits (-6..+6) maps to an intermediate carry and an intermediate sum. A raw sum above +2 gives carry +1 and sum raw-4. A raw sum below -2 gives carry -1 and sum raw+4. Any other raw sum gives carry 0 and sum raw.
- R4: Result digit k equals the intermediate sum of position k plus the intermediate carry of position k-1. Position 0 receives 0. Result digit NDIG equals the intermediate carry of the top position.
- R5: When `sub_i` is 1, each digit of the second operand is negated before R3 is applied, and the result encodes A−B.
- R6: `res_val_o`, the sum of digit k times 4^k, equals A+B (or A−B) in two's complement.
- R7: Both outputs update one clock cycle after the inputs are sampled, and do so on every cycle.
- R8: While `rst` is high at a rising edge, both outputs are cleared to zero.
- R9: The most significant output digit always lies in -1..+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sub_i | input | 1 | 1 selects A−B, 0 selects A+B |
| a_i | input | 2·NDIG | Operand A, two's complement |
| b_i | input | 2·NDIG | Operand B, two's complement |
| res_dig_o | output | 3·(NDIG+1) | Result as signed digits, digit 0 in the low bits |
| res_val_o | output | 2·NDIG+2 | Result as a two's complement value |

## Verification
Both results are due exactly one rising edge after the operands and the mode are applied. The bench drives on the falling edge and pushes the expected digit vector and value into queues. At the next falling edge it pops them and compares them with the outputs, so every check lands on the cycle in which the registered outputs hold that stimulus. The run sweeps every pair of 8-bit signed operands in both modes. Reset is checked before the sweep and again after it, in the cycles while `rst` is held.

// File: rtl/qsd_pkg.sv
package qsd_pkg;
  localparam int DIG_W = 3;
  typedef logic signed [DIG_W-1:0] qdigit_t;
endpackage

// File: rtl/qsd_split.sv
// Two's complement operand -> radix-4 signed digits (R2).
module qsd_split
  import qsd_pkg::*;
#(
  parameter int NDIG = 4,
  localparam int OP_W = 2 * NDIG
) (
  input  logic [OP_W-1:0]       bin_i,
  output logic [NDIG*DIG_W-1:0] dig_o
);
  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    if (k < NDIG - 1) begin : g_low
      assign dig_o[DIG_W*k +: DIG_W] = {1'b0, bin_i[2*k +: 2]};
    end else begin : g_top
      assign dig_o[DIG_W*k +: DIG_W] = {bin_i[OP_W-1], bin_i[OP_W-1 -: 2]};
    end
  end
endmodule

// File: rtl/qsd_digit_pre.sv
// First step: raw digit sum -> intermediate carry/sum (R3).
module qsd_digit_pre
  import qsd_pkg::*;
(
  input  qdigit_t x_i,
  input  qdigit_t y_i,
  output qdigit_t carry_o,
  output qdigit_t isum_o
);
  logic signed [3:0] raw;
  assign raw = 4'(x_i) + 4'(y_i);

  always_comb begin
    if (raw > 4'sd2) begin
      carry_o = 3'sd1;
      isum_o  = 3'(raw - 4'sd4);
    end else if (raw < -4'sd2) begin
      carry_o = -3'sd1;
      isum_o  = 3'(raw + 4'sd4);
    end else begin
      carry_o = '0;
      isum_o  = 3'(raw);
    end
  end
endmodule

// File: rtl/qsd_addsub_core.sv
// Digit-parallel add/subtract, no chain longer than one position (R4, R5).
module qsd_addsub_core
  import qsd_pkg::*;
#(
  parameter int NDIG = 4,
  localparam int IN_W  = NDIG * DIG_W,
  localparam int OUT_W = (NDIG + 1) * DIG_W
) (
  input  logic             sub_i,
  input  logic [IN_W-1:0]  a_dig_i,
  input  logic [IN_W-1:0]  b_dig_i,
  output logic [OUT_W-1:0] res_dig_o
);
  qdigit_t cy [NDIG];
  qdigit_t is [NDIG];

  for (genvar k = 0; k < NDIG; k++) begin : g_pos
    qdigit_t b_d, b_eff;
    assign b_d   = b_dig_i[DIG_W*k +: DIG_W];
    assign b_eff = sub_i ? -b_d : b_d;

    qsd_digit_pre u_pre (
      .x_i    (a_dig_i[DIG_W*k +: DIG_W]),
      .y_i    (b_eff),
      .carry_o(cy[k]),
      .isum_o (is[k])
    );

    if (k == 0) begin : g_first
      assign res_dig_o[0 +: DIG_W] = is[0];
    end else begin : g_rest
      assign res_dig_o[DIG_W*k +: DIG_W] = is[k] + cy[k-1];
    end
  end

  assign res_dig_o[DIG_W*NDIG +: DIG_W] = cy[NDIG-1];
endmodule

// File: rtl/qsd_merge.sv
// Signed digits -> two's complement value (R6).
module qsd_merge
  import qsd_pkg::*;
#(
  parameter int NDIG = 4,
  localparam int IN_W  = (NDIG + 1) * DIG_W,
  localparam int RES_W = 2 * NDIG + 2
) (
  input  logic [IN_W-1:0]         dig_i,
  output logic signed [RES_W-1:0] val_o
);
  always_comb begin
    val_o = '0;
    for (int k = 0; k <= NDIG; k++) begin
      val_o = val_o + (RES_W'(signed'(dig_i[DIG_W*k +: DIG_W])) <<< (2 * k));
    end
  end
endmodule

// File: rtl/qsd_addsub.sv
module qsd_addsub
  import qsd_pkg::*;
#(
  parameter int NDIG = 4,
  localparam int OP_W  = 2 * NDIG,
  localparam int DW    = (NDIG + 1) * DIG_W,
  localparam int RES_W = 2 * NDIG + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sub_i,
  input  logic [OP_W-1:0]         a_i,
  input  logic [OP_W-1:0]         b_i,
  output logic [DW-1:0]           res_dig_o,
  output logic signed [RES_W-1:0] res_val_o
);
  logic [NDIG*DIG_W-1:0]   a_dig, b_dig;
  logic [DW-1:0]           sum_dig;
  logic signed [RES_W-1:0] sum_val;

  qsd_split #(.NDIG(NDIG)) u_split_a (.bin_i(a_i), .dig_o(a_dig));
  qsd_split #(.NDIG(NDIG)) u_split_b (.bin_i(b_i), .dig_o(b_dig));

  qsd_addsub_core #(.NDIG(NDIG)) u_core (
    .sub_i    (sub_i),
    .a_dig_i  (a_dig),
    .b_dig_i  (b_dig),
    .res_dig_o(sum_dig)
  );

  qsd_merge #(.NDIG(NDIG)) u_merge (.dig_i(sum_dig), .val_o(sum_val));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_dig_o <= '0;
      res_val_o <= '0;
    end else begin
      res_dig_o <= sum_dig;
      res_val_o <= sum_val;
    end
  end
endmodule

// File: rtl/qsd_addsub_chk.sv
module qsd_addsub_chk
  import qsd_pkg::*;
#(
  parameter int NDIG = 4,
  localparam int OP_W  = 2 * NDIG,
  localparam int DW    = (NDIG + 1) * DIG_W,
  localparam int RES_W = 2 * NDIG + 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    sub_i,
  input logic [OP_W-1:0]         a_i,
  input logic [OP_W-1:0]         b_i,
  input logic [DW-1:0]           res_dig_o,
  input logic signed [RES_W-1:0] res_val_o
);
  logic signed [RES_W-1:0] exp_c;
  assign exp_c = sub_i ? RES_W'(signed'(a_i)) - RES_W'(signed'(b_i))
                       : RES_W'(signed'(a_i)) + RES_W'(signed'(b_i));

  for (genvar k = 0; k <= NDIG; k++) begin : g_rng
    assert_digit_code_R1: assert property (@(posedge clk) disable iff (rst)
      res_dig_o[DIG_W*k +: DIG_W] != 3'b100)
      else $error("digit %0d holds code 100", k);
  end

  assert_top_digit_R9: assert property (@(posedge clk) disable iff (rst)
    (signed'(res_dig_o[DW-1 -: DIG_W]) >= -3'sd1) && (signed'(res_dig_o[DW-1 -: DIG_W]) <= 3'sd1))
    else $error("top digit out of -1..+1");

  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (res_dig_o == '0) && (res_val_o == '0))
    else $error("outputs not cleared by reset");

  assert_value_next_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> res_val_o == $past(exp_c))
    else $error("result value differs from A+/-B");
endmodule

bind qsd_addsub qsd_addsub_chk #(.NDIG(NDIG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sub_i    (sub_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .res_dig_o(res_dig_o),
  .res_val_o(res_val_o)
);

// File: tb/qsd_addsub_tb_top.sv
module qsd_addsub_tb_top;
  localparam int NDIG  = 4;
  localparam int OP_W  = 2 * NDIG;
  localparam int DW    = (NDIG + 1) * 3;
  localparam int RES_W = 2 * NDIG + 2;
  localparam int WDOG  = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sub_i = 1'b0;
  logic [OP_W-1:0] a_i = '0;
  logic [OP_W-1:0] b_i = '0;
  logic [DW-1:0] res_dig_o;
  logic signed [RES_W-1:0] res_val_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [DW-1:0] exp_dig_q[$];
  int            exp_val_q[$];
  bit            exp_sub_q[$];

  always #10 clk = ~clk;

  qsd_addsub #(.NDIG(NDIG)) dut_i (
    .clk(clk), .rst(rst), .sub_i(sub_i), .a_i(a_i), .b_i(b_i),
    .res_dig_o(res_dig_o), .res_val_o(res_val_o)
  );

  // Reference digit vector built from R2, R3, R4, R5 with plain integers.
  function automatic logic [DW-1:0] model_digits(int av, int bv, bit sub);
    int ad, bd, raw;
    int cy[NDIG];
    int sm[NDIG];
    logic [DW-1:0] r;
    for (int k = 0; k < NDIG; k++) begin
      if (k < NDIG - 1) begin
        ad = (av >> (2 * k)) & 3;
        bd = (bv >> (2 * k)) & 3;
      end else begin
        ad = av >>> (2 * k);
        bd = bv >>> (2 * k);
      end
      if (sub) bd = -bd;
      raw = ad + bd;
      if (raw > 2)       begin cy[k] = 1;  sm[k] = raw - 4; end
      else if (raw < -2) begin cy[k] = -1; sm[k] = raw + 4; end
      else               begin cy[k] = 0;  sm[k] = raw;     end
    end
    for (int k = 0; k < NDIG; k++)
      r[3*k +: 3] = 3'((k == 0) ? sm[k] : sm[k] + cy[k-1]);
    r[3*NDIG +: 3] = 3'(cy[NDIG-1]);
    return r;
  endfunction

  function automatic int decode(logic [DW-1:0] d);
    int acc = 0;
    for (int k = 0; k <= NDIG; k++) acc += int'(signed'(d[3*k +: 3])) * (4 ** k);
    return acc;
  endfunction

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic pop_compare();
    logic [DW-1:0] ed;
    int ev;
    bit es;
    int td;
    bit bad;
    ed = exp_dig_q.pop_front();
    ev = exp_val_q.pop_front();
    es = exp_sub_q.pop_front();
    checks++;
    if (res_dig_o !== ed) begin
      errors++;
      $display("FAIL R2 R3 R4 digits: actual %h expected %h", res_dig_o, ed);
    end
    check_int(es ? "R5 R6 R7 value (subtract)" : "R6 R7 value (add)", int'(res_val_o), ev);
    check_int("R6 decoded digits", decode(res_dig_o), ev);
    bad = 1'b0;
    for (int k = 0; k <= NDIG; k++) if (res_dig_o[3*k +: 3] == 3'b100) bad = 1'b1;
    check_int("R1 digit codes in range (1 = code 100 seen)", int'(bad), 0);
    td = int'(signed'(res_dig_o[DW-1 -: 3]));
    check_int("R9 top digit magnitude at most 1", (td >= -1 && td <= 1) ? 1 : 0, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL R7 watchdog: actual %0d cycles expected below %0d", cycles, WDOG);
      report();
    end
  end

  initial begin
    // R8: reset held with non-zero stimulus keeps outputs at zero.
    @(negedge clk);
    a_i = 8'h5A; b_i = 8'hA3; sub_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check_int("R8 reset digits", int'(res_dig_o != '0), 0);
      check_int("R8 reset value", int'(res_val_o), 0);
    end

    rst = 1'b0;
    for (int s = 0; s < 2; s++) begin
      for (int av = -128; av < 128; av++) begin
        for (int bv = -128; bv < 128; bv++) begin
          sub_i = s[0];
          a_i = OP_W'(av);
          b_i = OP_W'(bv);
          exp_dig_q.push_back(model_digits(av, bv, s[0]));
          exp_val_q.push_back(s[0] ? av - bv : av + bv);
          exp_sub_q.push_back(s[0]);
          @(negedge clk);
          pop_compare();
        end
      end
    end

    // R8: reset applied again mid-run clears the registered result.
    a_i = 8'h7F; b_i = 8'h7F; sub_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check_int("R8 re-reset digits", int'(res_dig_o != '0), 0);
    check_int("R8 re-reset value", int'(res_val_o), 0);

    done = 1'b1;
    report();
  end
endmodule